// File: doc/BRIEF.md
# SRAM Fill-and-Verify Self-Test Engine

This block is a compact self-test engine bundled with its own 16-word by 8-bit synchronous storage array. When a start request arrives on the control byte, the engine captures a 4-bit pattern and widens it to a byte by placing four zero bits above it. It writes that byte to every address in ascending order. It then reads every address back, again in ascending order, and checks each returned byte against the expected one.

The outcome appears on a packed status byte. One bit says the pass has finished, and a second, sticky bit says at least one word did not match. The remaining status bits, the spare bidirectional outputs and their output enables are held low. The write-enable bit and the 2-bit mode field on the control byte are decoded but have no effect, and the same holds for the auxiliary address input.

A test-only corruption hook has two parts: a word index and an XOR mask. Both are captured at launch. While the fill runs, the engine XORs the mask into the byte written at that one index. This lets a bench force a known mismatch.

Top module: `sram_bist_top`

## Requirements
- R1: After the asynchronous active-low reset is released, the status byte reads 0x00 and both bidirectional output bytes read 0x00.
- R2: A start (control bit 7 high) seen on a rising edge in the idle or finished state launches a pass. Done (status bit 7) rises exactly 33 rising edges after that launch edge: 16 write cycles, 16 read cycles and one final compare cycle.
- R3: The expected byte is the 4-bit pattern from control bits 3:0 with four zero bits above it (pattern 0xA gives 0x0A). With a zero corruption mask, fail (status bit 6) stays low for every pattern.
- R4: A nonzero corruption mask for word k makes fail rise exactly 18+k rising edges after the launch edge. This is one cycle after word k is read, and it holds for mask bits in either nibble.
- R5: Once set, fail stays high through the rest of the pass and while the engine waits in the finished state.
- R6: Done stays high in the finished state until a new start is seen. The launch edge of a new pass clears both done and fail.
- R7: A start seen while writing or reading is ignored. Changes to the pattern, the corruption index or the corruption mask after the launch edge do not alter the result of the pass.
- R8: Control bits 6:4 and the auxiliary address input have no effect on the status byte or its timing.
- R9: Status bits 5:0, the bidirectional output byte and the output-enable byte are always 0.
- R10: Reset asserted in the middle of a pass clears done and fail at once and returns the engine to idle. A later start runs a complete pass with the normal timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 8 | Control byte: bit 7 start, bit 6 spare write enable, bits 5:4 mode (ignored), bits 3:0 pattern |
| ext_addr_i | input | 8 | Auxiliary address input, decoded and ignored |
| flip_addr_i | input | 4 | Test hook: word index to corrupt, captured at launch |
| flip_mask_i | input | 8 | Test hook: XOR mask for that word, captured at launch (0 = none) |
| status_o | output | 8 | Bit 7 done, bit 6 fail, bits 5:0 zero |
| bidir_out_o | output | 8 | Spare bidirectional outputs, held 0 |
| bidir_oe_o | output | 8 | Output enables for the spare lines, held 0 |

## Verification
The assertions assume three things about the inputs. Start is a synchronous level. The hook inputs matter only on the launch edge. Reset is the only thing that can clear the flags outside a launch. Under these assumptions, a falling done or fail must always follow a sampled start. The stimulus changes every input on the falling clock edge and releases reset there as well. While a pass is running, it randomises start, the ignored control bits, the auxiliary address and the hook inputs. It drops start only from the cycle after done rises, so every relaunch is deliberate and the flag-clearing assumption stays true.

// File: rtl/sram_bist_pkg.sv
package sram_bist_pkg;

    // Controller phases, 2-bit encoding
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_DONE  = 2'd3
    } bist_state_e;

endpackage

// File: rtl/sram_bist_mem.sv
module sram_bist_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;

    // storage array: synchronous write, no reset
    always_ff @(posedge clk) begin
        if (we_i) begin
            store_q[waddr_i] <= wdata_i;
        end
    end

    // synchronous read: data appears one cycle after the address
    always_comb begin
        rdata_d = rdata_q;
        if (re_i) begin
            rdata_d = store_q[raddr_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/sram_bist_ctrl.sv
module sram_bist_ctrl
    import sram_bist_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAT_W  = 4,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PAT_W-1:0]  pat_i,
    input  logic [ADDR_W-1:0] flip_addr_i,
    input  logic [DATA_W-1:0] flip_mask_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              re_o,
    output logic [ADDR_W-1:0] raddr_o,
    output logic              done_o,
    output logic              fail_o,
    output bist_state_e       state_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        bist_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] expect_byte;
        logic [ADDR_W-1:0] flip_addr;
        logic [DATA_W-1:0] flip_mask;
        logic              reads_issued;
        logic              cmp_vld;
        logic              cmp_last;
        logic              done;
        logic              fail;
    } ctrl_regs_t;

    ctrl_regs_t r_q;
    ctrl_regs_t r_d;

    logic              we_d;
    logic              re_d;
    logic              mismatch_d;
    logic [DATA_W-1:0] wdata_d;

    always_comb begin
        r_d        = r_q;
        we_d       = 1'b0;
        re_d       = 1'b0;
        wdata_d    = r_q.expect_byte;
        mismatch_d = r_q.cmp_vld && (rdata_i != r_q.expect_byte);

        if (r_q.addr == r_q.flip_addr) begin
            wdata_d = r_q.expect_byte ^ r_q.flip_mask;
        end

        unique case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.state        = ST_WRITE;
                    r_d.addr         = '0;
                    r_d.expect_byte  = DATA_W'(pat_i);
                    r_d.flip_addr    = flip_addr_i;
                    r_d.flip_mask    = flip_mask_i;
                    r_d.reads_issued = 1'b0;
                    r_d.done         = 1'b0;
                    r_d.fail         = 1'b0;
                end
            end
            ST_WRITE: begin
                we_d     = 1'b1;
                r_d.addr = r_q.addr + 1'b1;
                if (r_q.addr == LAST_ADDR) begin
                    r_d.state        = ST_READ;
                    r_d.addr         = '0;
                    r_d.reads_issued = 1'b0;
                end
            end
            ST_READ: begin
                if (!r_q.reads_issued) begin
                    re_d = 1'b1;
                    if (r_q.addr == LAST_ADDR) begin
                        r_d.reads_issued = 1'b1;
                    end else begin
                        r_d.addr = r_q.addr + 1'b1;
                    end
                end
                if (mismatch_d) begin
                    r_d.fail = 1'b1;
                end
                if (r_q.cmp_vld && r_q.cmp_last) begin
                    r_d.state = ST_DONE;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase

        r_d.cmp_vld  = re_d;
        r_d.cmp_last = re_d && (r_q.addr == LAST_ADDR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign we_o    = we_d;
    assign waddr_o = r_q.addr;
    assign wdata_o = wdata_d;
    assign re_o    = re_d;
    assign raddr_o = r_q.addr;
    assign done_o  = r_q.done;
    assign fail_o  = r_q.fail;
    assign state_o = r_q.state;

endmodule

// File: rtl/sram_bist_top.sv
module sram_bist_top
    import sram_bist_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAT_W  = 4,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        ctrl_i,
    input  logic [7:0]        ext_addr_i,
    input  logic [ADDR_W-1:0] flip_addr_i,
    input  logic [DATA_W-1:0] flip_mask_i,
    output logic [7:0]        status_o,
    output logic [7:0]        bidir_out_o,
    output logic [7:0]        bidir_oe_o
);

    // control byte fields
    logic             start;
    logic             spare_wen;
    logic [1:0]       mode_sel;
    logic [PAT_W-1:0] pattern;

    assign start     = ctrl_i[7];
    assign spare_wen = ctrl_i[6];
    assign mode_sel  = ctrl_i[5:4];
    assign pattern   = ctrl_i[PAT_W-1:0];

    // decoded fields with no function
    logic unused_fields;
    assign unused_fields = ^{spare_wen, mode_sel, ext_addr_i, ctrl_i[3:PAT_W]};

    logic              mem_we;
    logic              mem_re;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              done;
    logic              fail;
    bist_state_e       fsm_state;

    sram_bist_ctrl #(
        .DATA_W (DATA_W),
        .PAT_W  (PAT_W),
        .DEPTH  (DEPTH)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .pat_i       (pattern),
        .flip_addr_i (flip_addr_i),
        .flip_mask_i (flip_mask_i),
        .rdata_i     (mem_rdata),
        .we_o        (mem_we),
        .waddr_o     (mem_waddr),
        .wdata_o     (mem_wdata),
        .re_o        (mem_re),
        .raddr_o     (mem_raddr),
        .done_o      (done),
        .fail_o      (fail),
        .state_o     (fsm_state)
    );

    sram_bist_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .re_i    (mem_re),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );

    assign status_o    = {done, fail, 6'b0};
    assign bidir_out_o = '0;
    assign bidir_oe_o  = '0;

endmodule

module sram_bist_chk
    import sram_bist_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [7:0]  status,
    input logic [7:0]  bidir_out,
    input logic [7:0]  bidir_oe,
    input bist_state_e state
);

    // R9
    spare_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5:0] == 6'b0) && (bidir_out == 8'h00) && (bidir_oe == 8'h00));

    // R6
    done_clear_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[7]) |-> $past(start));

    // R5
    fail_clear_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[6]) |-> $past(start));

    // R6
    done_in_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> status[7]);

    // R4
    fail_set_on_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> ((state == ST_READ) || (state == ST_DONE)));

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |=> ((state == ST_WRITE) || (state == ST_READ)));

endmodule

bind sram_bist_top sram_bist_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ctrl_i[7]),
    .status    (status_o),
    .bidir_out (bidir_out_o),
    .bidir_oe  (bidir_oe_o),
    .state     (fsm_state)
);

// File: tb/sram_bist_top_test.sv
module sram_bist_top_test;

    localparam int DEPTH = 16;
    localparam int LAT   = 2 * DEPTH + 1;  // edges from launch to done
    localparam int CMP0  = DEPTH + 2;      // edges from launch to compare of word 0

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctrl_i = 8'h00;
    logic [7:0] ext_addr_i = 8'h00;
    logic [3:0] flip_addr_i = 4'h0;
    logic [7:0] flip_mask_i = 8'h00;
    logic [7:0] status_o;
    logic [7:0] bidir_out_o;
    logic [7:0] bidir_oe_o;

    int vectors = 0;
    int misses  = 0;

    always #2 clk = ~clk;

    sram_bist_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_i      (ctrl_i),
        .ext_addr_i  (ext_addr_i),
        .flip_addr_i (flip_addr_i),
        .flip_mask_i (flip_mask_i),
        .status_o    (status_o),
        .bidir_out_o (bidir_out_o),
        .bidir_oe_o  (bidir_oe_o)
    );

    function automatic logic [7:0] exp_status(input int edge_no, input logic [3:0] faddr,
                                              input logic [7:0] fmask);
        logic d;
        logic f;
        d = (edge_no >= LAT);
        f = (fmask != 8'h00) && (edge_no >= CMP0 + int'(faddr));
        return {d, f, 6'b0};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        vectors++;
        if (act !== expv) begin
            misses++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, expv, $time);
        end
    endtask

    // full pass; noisy randomises every ignored input after the launch edge (R7, R8)
    task automatic run_pass(input logic [3:0] pat, input logic [3:0] faddr,
                            input logic [7:0] fmask, input bit noisy);
        @(negedge clk);
        ctrl_i      = {1'b1, 3'($urandom), pat};
        ext_addr_i  = 8'($urandom);
        flip_addr_i = faddr;
        flip_mask_i = fmask;
        @(negedge clk);
        // R6: launch edge clears both flags
        check("R6", status_o, 8'h00);
        for (int i = 1; i <= LAT; i++) begin
            if (noisy) begin
                ctrl_i      = {1'($urandom), 7'($urandom)};
                ext_addr_i  = 8'($urandom);
                flip_addr_i = 4'($urandom);
                flip_mask_i = 8'($urandom);
            end else begin
                ctrl_i = {1'b0, 3'($urandom), pat};
            end
            @(negedge clk);
            // R2 done timing, R3 pass result, R4 fail timing
            check((i == LAT) ? "R2" : ((fmask != 0) ? "R4" : "R3"),
                  status_o, exp_status(i, faddr, fmask));
        end
        ctrl_i = {1'b0, 7'($urandom)};
        ext_addr_i = 8'($urandom);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            // R5 sticky fail, R6 done held
            check("R5", status_o, exp_status(LAT, faddr, fmask));
        end
        // R9
        check("R9", bidir_out_o | bidir_oe_o, 8'h00);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1
        check("R1", status_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", status_o, 8'h00);
        check("R1", bidir_out_o | bidir_oe_o, 8'h00);

        // directed corners
        run_pass(4'hA, 4'h0, 8'h00, 1'b0);   // R3 pattern 0x0A
        run_pass(4'hF, 4'h3, 8'h00, 1'b1);   // R3, R7, R8
        run_pass(4'h0, 4'h0, 8'h01, 1'b0);   // R4 first word
        run_pass(4'h5, 4'hF, 8'h80, 1'b1);   // R4 last word, upper nibble
        run_pass(4'h5, 4'h7, 8'h00, 1'b0);   // R6 clears after fail pass

        // R10: reset in the middle of a pass
        @(negedge clk);
        ctrl_i = 8'h86;
        @(negedge clk);
        ctrl_i = 8'h00;
        repeat (12) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10", status_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        run_pass(4'h6, 4'h2, 8'h10, 1'b0);

        // random passes
        for (int n = 0; n < 24; n++) begin
            logic [7:0] m;
            m = (($urandom % 3) == 0) ? 8'h00 : 8'($urandom);
            run_pass(4'($urandom), 4'($urandom), m, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule